// File: doc/BRIEF.md
# Fail-First Vector Length Truncator

This block sits after the execution stage of a vector unit. It receives every element result of one vector operation in a single cycle. When fail-first mode is on, it finds the earliest element that failed and cuts the active vector length down to that element's index. All elements before that point commit normally, so the operation never has to fall back to scalar execution.

For arithmetic operations, an element fails when its result is zero. For loads, an element fails when its access-fault flag is set. If the very first load element faults, a shortened length would be meaningless, so the block raises a trap request and keeps the length unchanged. Results appear one clock after the input strobe. They consist of the new length, a flag saying the length was shortened, a trap request, and one commit bit per element.

Top module: `fof_truncator`

## Requirements
- R1: `outValid` is high exactly one clock after a cycle with `inValid` high, and low one clock after a cycle with `inValid` low.
- R2: With `ffEnable` low, `vlOut` equals `vlIn` (after the clamp of R5), and `truncated` and `trapReq` are both low, whatever the data or fault inputs are.
- R3: With `ffEnable` high and `opKind` = 0 (arithmetic), lane i fails when `elemData[i*DATA_W +: DATA_W]` is zero. When a lane fails, `vlOut` becomes the index of the failing lane and `truncated` goes high.
- R4: With `ffEnable` high and `opKind` = 1 (load), lane i fails when `elemFault[i]` is set. When a lane at index 1 or higher fails, `vlOut` becomes that index and `truncated` goes high.
- R5: Lanes at or above the incoming length are never examined. A `vlIn` above NUM_ELEM is treated as NUM_ELEM. `vlOut` never exceeds the incoming length.
- R6: When several lanes fail, only the lowest-indexed one sets `vlOut`.
- R7: A load fault in lane 0 with `ffEnable` high sets `trapReq` high, keeps `vlOut` at the incoming length, keeps `truncated` low, and clears all of `commitMask`.
- R8: An arithmetic zero in lane 0 gives `vlOut` = 0 with `truncated` high, and never raises `trapReq`.
- R9: `commitMask[i]` is 1 exactly when i < `vlOut` and `trapReq` is low.
- R10: After reset, `outValid`, `vlOut`, `truncated`, `trapReq` and `commitMask` are all zero.
- R11: Arithmetic operations ignore `elemFault`, and loads ignore `elemData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Element results are present this cycle |
| ffEnable | input | 1 | Fail-first mode enable |
| opKind | input | 1 | 0 = arithmetic, 1 = load |
| vlIn | input | VL_W (4) | Incoming vector length |
| elemData | input | NUM_ELEM*DATA_W (128) | Per-lane arithmetic results, lane i at bits i*DATA_W |
| elemFault | input | NUM_ELEM (8) | Per-lane load access-fault flags |
| outValid | output | 1 | Registered results are valid |
| vlOut | output | VL_W (4) | Resulting vector length |
| truncated | output | 1 | The length was shortened |
| trapReq | output | 1 | Trap request: load fault in lane 0 |
| commitMask | output | NUM_ELEM (8) | Per-lane commit enables |

## Verification
The assertions check on every cycle:
- the strobe timing;
- that bypass mode never shortens or traps;
- that arithmetic operations never trap;
- that a trap clears the commit mask;
- that the commit mask is a contiguous run of low lanes whose population equals `vlOut`;
- that the length never grows.

Only the bench's scenarios can show which lane wins when several fail, and that lanes above the length are ignored. The same holds for the per-operation choice between zero data and fault flags, and for the exact truncated length, because these depend on the lane contents.

// File: rtl/fof_pkg.sv
package fof_pkg;
  typedef enum logic {
    OP_ALU  = 1'b0,
    OP_LOAD = 1'b1
  } opKind_e;

  // compare enables from control to datapath
  typedef struct packed {
    logic aluCmpEn;
    logic loadChkEn;
  } cmpCtrl_t;

  // result-selection strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic truncate;
    logic trap;
  } outCtrl_t;
endpackage

// File: rtl/fof_control.sv
module fof_control
  import fof_pkg::*;
(
  input  logic     inValid,
  input  logic     ffEnable,
  input  logic     opKind,
  input  logic     anyFail,
  input  logic     firstIsLane0,
  output cmpCtrl_t cmpCtrl,
  output outCtrl_t outCtrl
);
  opKind_e opSel;

  always_comb begin
    opSel = opKind_e'(opKind);
    cmpCtrl.aluCmpEn  = ffEnable && (opSel == OP_ALU);
    cmpCtrl.loadChkEn = ffEnable && (opSel == OP_LOAD);
  end

  always_comb begin
    outCtrl.capture  = inValid;
    outCtrl.trap     = anyFail && firstIsLane0 && (opSel == OP_LOAD);
    outCtrl.truncate = anyFail && !outCtrl.trap;
  end
endmodule

// File: rtl/fof_datapath.sv
module fof_datapath
  import fof_pkg::*;
#(
  parameter int NUM_ELEM = 8,
  parameter int DATA_W   = 16,
  localparam int VL_W    = $clog2(NUM_ELEM + 1),
  localparam int IDX_W   = (NUM_ELEM > 1) ? $clog2(NUM_ELEM) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [VL_W-1:0]            vlIn,
  input  logic [NUM_ELEM*DATA_W-1:0] elemData,
  input  logic [NUM_ELEM-1:0]        elemFault,
  input  cmpCtrl_t                   cmpCtrl,
  input  outCtrl_t                   outCtrl,
  output logic                       anyFail,
  output logic                       firstIsLane0,
  output logic                       outValid,
  output logic [VL_W-1:0]            vlOut,
  output logic                       truncated,
  output logic                       trapReq,
  output logic [NUM_ELEM-1:0]        commitMask
);
  localparam logic [VL_W-1:0] VL_MAX = VL_W'(NUM_ELEM);

  logic [VL_W-1:0]     vlEff;
  logic [NUM_ELEM-1:0] laneLive;
  logic [NUM_ELEM-1:0] laneFail;
  logic [IDX_W-1:0]    firstIdx;
  logic [VL_W-1:0]     nextVl;
  logic [NUM_ELEM-1:0] nextMask;

  assign vlEff = (vlIn > VL_MAX) ? VL_MAX : vlIn;

  for (genvar i = 0; i < NUM_ELEM; i++) begin : g_lane
    logic isZero;
    assign laneLive[i] = VL_W'(i) < vlEff;
    assign isZero      = cmpCtrl.aluCmpEn && (elemData[i*DATA_W +: DATA_W] == '0);
    assign laneFail[i] = laneLive[i] &&
                         (isZero || (cmpCtrl.loadChkEn && elemFault[i]));
  end

  // lowest failing lane wins: scan from the top down
  always_comb begin
    firstIdx = '0;
    for (int i = NUM_ELEM - 1; i >= 0; i--) begin
      if (laneFail[i]) firstIdx = IDX_W'(i);
    end
  end

  assign anyFail      = |laneFail;
  assign firstIsLane0 = laneFail[0];

  always_comb begin
    if (outCtrl.truncate) nextVl = VL_W'(firstIdx);
    else                  nextVl = vlEff;
  end

  for (genvar i = 0; i < NUM_ELEM; i++) begin : g_mask
    assign nextMask[i] = !outCtrl.trap && (VL_W'(i) < nextVl);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      vlOut      <= '0;
      truncated  <= 1'b0;
      trapReq    <= 1'b0;
      commitMask <= '0;
    end else begin
      outValid <= outCtrl.capture;
      if (outCtrl.capture) begin
        vlOut      <= nextVl;
        truncated  <= outCtrl.truncate;
        trapReq    <= outCtrl.trap;
        commitMask <= nextMask;
      end
    end
  end
endmodule

// File: rtl/fof_truncator.sv
module fof_truncator
  import fof_pkg::*;
#(
  parameter int NUM_ELEM = 8,
  parameter int DATA_W   = 16,
  localparam int VL_W    = $clog2(NUM_ELEM + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       inValid,
  input  logic                       ffEnable,
  input  logic                       opKind,
  input  logic [VL_W-1:0]            vlIn,
  input  logic [NUM_ELEM*DATA_W-1:0] elemData,
  input  logic [NUM_ELEM-1:0]        elemFault,
  output logic                       outValid,
  output logic [VL_W-1:0]            vlOut,
  output logic                       truncated,
  output logic                       trapReq,
  output logic [NUM_ELEM-1:0]        commitMask
);
  cmpCtrl_t cmpCtrl;
  outCtrl_t outCtrl;
  logic     anyFail;
  logic     firstIsLane0;

  fof_control u_ctrl (
    .inValid(inValid), .ffEnable(ffEnable), .opKind(opKind),
    .anyFail(anyFail), .firstIsLane0(firstIsLane0),
    .cmpCtrl(cmpCtrl), .outCtrl(outCtrl)
  );

  fof_datapath #(.NUM_ELEM(NUM_ELEM), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .vlIn(vlIn), .elemData(elemData),
    .elemFault(elemFault), .cmpCtrl(cmpCtrl), .outCtrl(outCtrl),
    .anyFail(anyFail), .firstIsLane0(firstIsLane0),
    .outValid(outValid), .vlOut(vlOut), .truncated(truncated),
    .trapReq(trapReq), .commitMask(commitMask)
  );
endmodule

// File: rtl/fof_checker.sv
module fof_checker #(
  parameter int NUM_ELEM = 8,
  localparam int VL_W    = $clog2(NUM_ELEM + 1)
) (
  input logic                clk,
  input logic                rstN,
  input logic                inValid,
  input logic                ffEnable,
  input logic                opKind,
  input logic [VL_W-1:0]     vlIn,
  input logic                outValid,
  input logic [VL_W-1:0]     vlOut,
  input logic                truncated,
  input logic                trapReq,
  input logic [NUM_ELEM-1:0] commitMask
);
  logic [NUM_ELEM-1:0] maskInc;
  assign maskInc = commitMask + NUM_ELEM'(1);

  AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R1
  AST_STROBE_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid); // R1
  AST_BYPASS_KEEPS_VL: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !ffEnable) |=> (!truncated && !trapReq)); // R2
  AST_NEVER_LONGER: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (vlOut <= $past(vlIn))); // R5
  AST_TRAP_CLEARS_MASK: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> (!truncated && commitMask == '0)); // R7
  AST_ALU_NO_TRAP: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !opKind) |=> !trapReq); // R8
  AST_MASK_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !trapReq) |-> ($countones(commitMask) == int'(vlOut))); // R9
  AST_MASK_CONTIG: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ((maskInc & commitMask) == '0)); // R9
endmodule

bind fof_truncator fof_checker #(.NUM_ELEM(NUM_ELEM)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .ffEnable(ffEnable),
  .opKind(opKind), .vlIn(vlIn), .outValid(outValid), .vlOut(vlOut),
  .truncated(truncated), .trapReq(trapReq), .commitMask(commitMask)
);

// File: tb/tb_fof_truncator.sv
module tb_fof_truncator;
  localparam int NUM_ELEM = 8;
  localparam int DATA_W   = 16;
  localparam int VL_W     = 4;
  localparam int NVEC     = 15;

  logic                       clk = 1'b0;
  logic                       rstN = 1'b0;
  logic                       inValid = 1'b0;
  logic                       ffEnable = 1'b0;
  logic                       opKind = 1'b0;
  logic [VL_W-1:0]            vlIn = '0;
  logic [NUM_ELEM*DATA_W-1:0] elemData = '0;
  logic [NUM_ELEM-1:0]        elemFault = '0;
  logic                       outValid;
  logic [VL_W-1:0]            vlOut;
  logic                       truncated;
  logic                       trapReq;
  logic [NUM_ELEM-1:0]        commitMask;

  int applied = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  fof_truncator #(.NUM_ELEM(NUM_ELEM), .DATA_W(DATA_W)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .ffEnable(ffEnable),
    .opKind(opKind), .vlIn(vlIn), .elemData(elemData), .elemFault(elemFault),
    .outValid(outValid), .vlOut(vlOut), .truncated(truncated),
    .trapReq(trapReq), .commitMask(commitMask)
  );

  // {req[31:28], ff[27], op[26], vl[25:22], zeroLanes[21:14], faults[13:6],
  //  expVl[5:2], expTrunc[1], expTrap[0]}
  localparam logic [31:0] VECS [NVEC] = '{
    {4'd3,  1'b1, 1'b0, 4'd8,  8'h00, 8'h00, 4'd8, 1'b0, 1'b0}, // R3 no zero
    {4'd3,  1'b1, 1'b0, 4'd8,  8'h10, 8'h00, 4'd4, 1'b1, 1'b0}, // R3 lane 4
    {4'd6,  1'b1, 1'b0, 4'd8,  8'h28, 8'h00, 4'd3, 1'b1, 1'b0}, // R6 lanes 3,5
    {4'd5,  1'b1, 1'b0, 4'd3,  8'h08, 8'h00, 4'd3, 1'b0, 1'b0}, // R5 beyond vl
    {4'd2,  1'b0, 1'b0, 4'd6,  8'h01, 8'h00, 4'd6, 1'b0, 1'b0}, // R2 alu off
    {4'd4,  1'b1, 1'b1, 4'd8,  8'h00, 8'h40, 4'd6, 1'b1, 1'b0}, // R4 lane 6
    {4'd7,  1'b1, 1'b1, 4'd5,  8'h00, 8'h01, 4'd5, 1'b0, 1'b1}, // R7 trap
    {4'd8,  1'b1, 1'b0, 4'd5,  8'h01, 8'h00, 4'd0, 1'b1, 1'b0}, // R8 alu lane 0
    {4'd11, 1'b1, 1'b1, 4'd7,  8'hFF, 8'h00, 4'd7, 1'b0, 1'b0}, // R11 load ignores data
    {4'd11, 1'b1, 1'b0, 4'd7,  8'h00, 8'hFF, 4'd7, 1'b0, 1'b0}, // R11 alu ignores faults
    {4'd2,  1'b0, 1'b1, 4'd4,  8'h00, 8'h01, 4'd4, 1'b0, 1'b0}, // R2 load off
    {4'd5,  1'b1, 1'b1, 4'd4,  8'h00, 8'hF0, 4'd4, 1'b0, 1'b0}, // R5 faults above vl
    {4'd6,  1'b1, 1'b1, 4'd8,  8'h00, 8'h0C, 4'd2, 1'b1, 1'b0}, // R6 lanes 2,3
    {4'd5,  1'b1, 1'b0, 4'd0,  8'hFF, 8'h00, 4'd0, 1'b0, 1'b0}, // R5 vl zero
    {4'd5,  1'b1, 1'b0, 4'd12, 8'h00, 8'h00, 4'd8, 1'b0, 1'b0}  // R5 clamp
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [NUM_ELEM-1:0] expMask(input int vl, input bit trap);
    logic [NUM_ELEM-1:0] m = '0;
    for (int i = 0; i < NUM_ELEM; i++) if (!trap && i < vl) m[i] = 1'b1;
    return m;
  endfunction

  task automatic runVec(input logic [31:0] v);
    string tag;
    tag = $sformatf("R%0d", int'(v[31:28]));
    @(negedge clk);
    inValid   = 1'b1;
    ffEnable  = v[27];
    opKind    = v[26];
    vlIn      = v[25:22];
    elemFault = v[13:6];
    for (int i = 0; i < NUM_ELEM; i++)
      elemData[i*DATA_W +: DATA_W] = v[14+i] ? '0 : DATA_W'((i + 1) * 16'h0111);
    @(negedge clk);
    inValid = 1'b0;
    check({tag, " outValid"}, 32'(outValid), 32'd1);          // R1
    check({tag, " vlOut"}, 32'(vlOut), 32'(v[5:2]));
    check({tag, " truncated"}, 32'(truncated), 32'(v[1]));
    check({tag, " trapReq"}, 32'(trapReq), 32'(v[0]));
    check({tag, " R9 mask"}, 32'(commitMask), 32'(expMask(int'(v[5:2]), v[0])));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 outValid", 32'(outValid), 32'd0);
    check("R10 vlOut", 32'(vlOut), 32'd0);
    check("R10 flags", 32'({truncated, trapReq}), 32'd0);
    check("R10 mask", 32'(commitMask), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle", 32'(outValid), 32'd0);
    for (int k = 0; k < NVEC; k++) runVec(VECS[k]);
    // R1 strobe drops a cycle after the input strobe
    @(negedge clk);
    check("R1 drop", 32'(outValid), 32'd0);
    // R7 trap then a normal load: the trap flag clears
    runVec({4'd7, 1'b1, 1'b1, 4'd8, 8'h00, 8'h03, 4'd8, 1'b0, 1'b1});
    runVec({4'd4, 1'b1, 1'b1, 4'd8, 8'h00, 8'h02, 4'd1, 1'b1, 1'b0});
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
    $finish;
  end
endmodule